// File: doc/BRIEF.md
# Banked Program Address Generator

This block produces the 24-bit instruction fetch address for a small processor core. The address is made of two registers: an 8-bit bank register that selects one of 256 regions of 64 KB, and a 16-bit program counter that selects a byte inside that region. In normal running the core asks for one of four updates. It can advance the counter by a small byte count, take a relative branch by a signed 16-bit offset, load a new counter value inside the current bank, or load bank and counter together for a long jump. When arithmetic on the counter carries out of the top bit or borrows below zero, the bank register moves by one. Software therefore never has to handle bank boundaries.

Leaving reset, the block starts itself. It reads a two-byte start vector from bank 0x00, the low byte from 0xFFFE and then the high byte from 0xFFFF. It loads the assembled value into the counter with the bank at 0x00, and only then accepts update requests. Memory answers each read through a read-data port qualified by a valid strobe.

Top module: `fetch_addr_gen`

## Requirements
- R1: While rst_n is low, fetch_addr is 0x00FFFE, busy is 1 and fetch_req is 0.
- R2: After reset releases, fetch_req is 1 and fetch_addr holds 0x00FFFE until the first mem_rvalid. It then holds 0x00FFFF until the second mem_rvalid. busy stays 1 through both reads.
- R3: The clock edge that takes the second vector byte clears busy and sets fetch_addr to {0x00, second byte, first byte}.
- R4: While busy is 1, every update request is ignored and fetch_addr changes only as R2 states.
- R5: With inc_req alone, the next fetch_addr is the current one plus inc_cnt (zero-extended). A carry out of counter bit 15 increments the bank.
- R6: With br_req, the next fetch_addr is the current one plus br_off sign-extended to 24 bits. A carry raises the bank by one and a borrow lowers it by one.
- R7: The bank wraps modulo 256: 0xFF plus a carry gives 0x00, and 0x00 minus a borrow gives 0xFF.
- R8: With ld_in_req, the counter takes ld_pc and the bank is unchanged.
- R9: With ld_long_req, the bank takes ld_bank and the counter takes ld_pc in the same cycle.
- R10: When several requests are active together, the order of precedence is ld_long_req, then ld_in_req, then br_req, then inc_req.
- R11: With no request active and busy at 0, fetch_addr holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_req | input | 1 | Advance the counter by inc_cnt |
| inc_cnt | input | 3 | Byte count for an advance |
| br_req | input | 1 | Relative branch |
| br_off | input | 16 | Signed branch offset |
| ld_in_req | input | 1 | Load the counter, keep the bank |
| ld_long_req | input | 1 | Load bank and counter |
| ld_bank | input | 8 | Bank value for a long load |
| ld_pc | input | 16 | Counter value for either load |
| mem_rdata | input | 8 | Read data for vector bytes |
| mem_rvalid | input | 1 | mem_rdata is valid for the current read |
| fetch_req | output | 1 | fetch_addr is a valid read address |
| fetch_addr | output | 24 | {bank, counter} fetch address |
| busy | output | 1 | Start vector fetch in progress |

## Verification
The bench aims at the bank edges. An advance from 0xFFFFFE must wrap to bank 0x00, and a negative branch from bank 0x00 must give bank 0xFF. A design that drops the carry, or that does not wrap the bank, stays in the wrong bank. Branches of +0x7FFF, +1 and -1 around a bank edge show whether the offset is sign-extended, since a zero-extended offset moves the bank in the wrong direction on -1. The bench also swaps the vector byte order, sends requests during the vector fetch and during reset, and turns on all requests together. A design with a bad priority order, or that accepts requests while busy, leaves the wrong address.

// File: rtl/pag_pkg.sv
package pag_pkg;
    typedef enum logic [1:0] {
        VEC_LO  = 2'd0,
        VEC_HI  = 2'd1,
        VEC_RUN = 2'd2
    } vec_state_e;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_INC       = 3'd1,
        OP_BRANCH    = 3'd2,
        OP_LOAD_IN   = 3'd3,
        OP_LOAD_LONG = 3'd4,
        OP_VECTOR    = 3'd5
    } op_e;
endpackage

// File: rtl/pag_op_select.sv
module pag_op_select
    import pag_pkg::*;
(
    input  logic busy,
    input  logic vec_done,
    input  logic ld_long_req,
    input  logic ld_in_req,
    input  logic br_req,
    input  logic inc_req,
    output op_e  op
);
    always_comb begin
        op = OP_NONE;
        if (vec_done)         op = OP_VECTOR;
        else if (busy)        op = OP_NONE;
        else if (ld_long_req) op = OP_LOAD_LONG;
        else if (ld_in_req)   op = OP_LOAD_IN;
        else if (br_req)      op = OP_BRANCH;
        else if (inc_req)     op = OP_INC;
    end
endmodule

// File: rtl/pag_vec_fetch.sv
module pag_vec_fetch
    import pag_pkg::*;
#(
    parameter int          PC_W     = 16,
    parameter logic [15:0] VEC_ADDR = 16'hFFFE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PC_W/2-1:0]     mem_rdata,
    input  logic                  mem_rvalid,
    output logic                  busy,
    output logic                  vec_done,
    output logic [PC_W-1:0]       vec_pc,
    output logic [PC_W-1:0]       vec_addr
);
    localparam int DATA_W = PC_W / 2;

    typedef struct packed {
        vec_state_e          st;
        logic [DATA_W-1:0]   lo;
    } vec_s;

    vec_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        vec_done = 1'b0;
        vec_pc   = {mem_rdata, s_q.lo};
        case (s_q.st)
            VEC_LO: if (mem_rvalid) begin
                s_d.lo = mem_rdata;
                s_d.st = VEC_HI;
            end
            VEC_HI: if (mem_rvalid) begin
                vec_done = 1'b1;
                s_d.st   = VEC_RUN;
            end
            default: s_d.st = VEC_RUN;
        endcase
        busy     = (s_q.st != VEC_RUN);
        vec_addr = (s_q.st == VEC_HI) ? PC_W'(VEC_ADDR) + PC_W'(1) : PC_W'(VEC_ADDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st <= VEC_LO;
            s_q.lo <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/pag_addr_reg.sv
module pag_addr_reg
    import pag_pkg::*;
#(
    parameter int          BANK_W = 8,
    parameter int          PC_W   = 16,
    parameter int          CNT_W  = 3,
    parameter logic [15:0] RST_PC = 16'hFFFE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  op_e                   op,
    input  logic [CNT_W-1:0]      inc_cnt,
    input  logic [PC_W-1:0]       br_off,
    input  logic [BANK_W-1:0]     ld_bank,
    input  logic [PC_W-1:0]       ld_pc,
    input  logic [PC_W-1:0]       vec_pc,
    output logic [BANK_W-1:0]     bank,
    output logic [PC_W-1:0]       pc
);
    localparam int AW = BANK_W + PC_W;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [PC_W-1:0]   pc;
    } addr_s;

    addr_s s_d, s_q;
    logic [AW-1:0] full, step, sum;

    always_comb begin
        full = {s_q.bank, s_q.pc};
        step = '0;
        if (op == OP_BRANCH) step = {{(AW-PC_W){br_off[PC_W-1]}}, br_off};
        else if (op == OP_INC) step = {{(AW-CNT_W){1'b0}}, inc_cnt};
        sum  = full + step;
        s_d  = s_q;
        case (op)
            OP_VECTOR: begin
                s_d.bank = '0;
                s_d.pc   = vec_pc;
            end
            OP_LOAD_LONG: begin
                s_d.bank = ld_bank;
                s_d.pc   = ld_pc;
            end
            OP_LOAD_IN: s_d.pc = ld_pc;
            OP_BRANCH, OP_INC: {s_d.bank, s_d.pc} = sum;
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.bank <= '0;
            s_q.pc   <= PC_W'(RST_PC);
        end else begin
            s_q <= s_d;
        end
    end

    assign bank = s_q.bank;
    assign pc   = s_q.pc;
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
    import pag_pkg::*;
#(
    parameter int          BANK_W   = 8,
    parameter int          PC_W     = 16,
    parameter int          CNT_W    = 3,
    parameter logic [15:0] VEC_ADDR = 16'hFFFE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inc_req,
    input  logic [CNT_W-1:0]         inc_cnt,
    input  logic                     br_req,
    input  logic [PC_W-1:0]          br_off,
    input  logic                     ld_in_req,
    input  logic                     ld_long_req,
    input  logic [BANK_W-1:0]        ld_bank,
    input  logic [PC_W-1:0]          ld_pc,
    input  logic [PC_W/2-1:0]        mem_rdata,
    input  logic                     mem_rvalid,
    output logic                     fetch_req,
    output logic [BANK_W+PC_W-1:0]   fetch_addr,
    output logic                     busy
);
    op_e               op;
    logic              vec_done;
    logic [PC_W-1:0]   vec_pc, vec_addr, pc;
    logic [BANK_W-1:0] bank;
    logic              live_d, live_q;

    pag_vec_fetch #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_vec (
        .clk, .rst_n, .mem_rdata, .mem_rvalid,
        .busy, .vec_done, .vec_pc, .vec_addr
    );

    pag_op_select u_sel (
        .busy, .vec_done, .ld_long_req, .ld_in_req, .br_req, .inc_req, .op
    );

    pag_addr_reg #(.BANK_W(BANK_W), .PC_W(PC_W), .CNT_W(CNT_W), .RST_PC(VEC_ADDR)) u_reg (
        .clk, .rst_n, .op, .inc_cnt, .br_off, .ld_bank, .ld_pc, .vec_pc, .bank, .pc
    );

    always_comb begin
        live_d     = 1'b1;
        fetch_req  = live_q;
        fetch_addr = busy ? {{BANK_W{1'b0}}, vec_addr} : {bank, pc};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= live_d;
    end
endmodule

// File: rtl/pag_chk.sv
module pag_chk #(
    parameter int BANK_W = 8,
    parameter int PC_W   = 16,
    parameter int CNT_W  = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   inc_req,
    input logic [CNT_W-1:0]       inc_cnt,
    input logic                   br_req,
    input logic [PC_W-1:0]        br_off,
    input logic                   ld_in_req,
    input logic                   ld_long_req,
    input logic [BANK_W-1:0]      ld_bank,
    input logic [PC_W-1:0]        ld_pc,
    input logic [PC_W/2-1:0]      mem_rdata,
    input logic                   mem_rvalid,
    input logic                   fetch_req,
    input logic [BANK_W+PC_W-1:0] fetch_addr,
    input logic                   busy
);
    localparam int AW = BANK_W + PC_W;

    // R2 R4
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rvalid) |=> (busy && $stable(fetch_addr)));

    // R3
    vec_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (fetch_addr[AW-1:PC_W] == '0));

    // R9
    long_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ld_long_req) |=> (fetch_addr == {$past(ld_bank), $past(ld_pc)}));

    // R8
    in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ld_in_req && !ld_long_req) |=>
        (fetch_addr == {$past(fetch_addr[AW-1:PC_W]), $past(ld_pc)}));

    // R6
    branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && br_req && !ld_in_req && !ld_long_req) |=>
        (fetch_addr == $past(fetch_addr) + {{(AW-PC_W){$past(br_off[PC_W-1])}}, $past(br_off)}));

    // R5
    inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && inc_req && !br_req && !ld_in_req && !ld_long_req) |=>
        (fetch_addr == $past(fetch_addr) + AW'($past(inc_cnt))));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !inc_req && !br_req && !ld_in_req && !ld_long_req) |=> $stable(fetch_addr));

    // R2
    req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> fetch_req);
endmodule

bind fetch_addr_gen pag_chk #(.BANK_W(BANK_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_fetch_addr_gen.sv
module sim_fetch_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_req = 1'b0, br_req = 1'b0, ld_in_req = 1'b0, ld_long_req = 1'b0;
    logic [2:0]  inc_cnt = '0;
    logic [15:0] br_off = '0, ld_pc = '0;
    logic [7:0]  ld_bank = '0, mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        fetch_req, busy;
    logic [23:0] fetch_addr;

    int n_chk = 0, n_bad = 0;
    logic [23:0] exp_a;

    always #10 clk = ~clk;

    fetch_addr_gen u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        inc_req = 0; br_req = 0; ld_in_req = 0; ld_long_req = 0; mem_rvalid = 0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic boot(logic [7:0] lo, logic [7:0] hi);
        @(negedge clk); rst_n = 0; clr();
        inc_req = 1; inc_cnt = 3'd2; ld_long_req = 1; ld_bank = 8'h55; ld_pc = 16'h1111;
        tick(); tick();
        check("R1 addr", fetch_addr, 24'h00FFFE);
        check("R1 busy", busy, 1);
        check("R1 req", fetch_req, 0);
        rst_n = 1; tick();
        check("R2 req", fetch_req, 1);
        check("R4 ignored while busy", fetch_addr, 24'h00FFFE);
        clr(); mem_rdata = lo; mem_rvalid = 1; tick(); mem_rvalid = 0;
        check("R2 second read", fetch_addr, 24'h00FFFF);
        check("R2 busy", busy, 1);
        br_req = 1; br_off = 16'h0100; tick(); clr();
        check("R4 ignored while busy", fetch_addr, 24'h00FFFF);
        mem_rdata = hi; mem_rvalid = 1; tick(); mem_rvalid = 0;
        check("R3 busy", busy, 0);
        check("R3 addr", fetch_addr, {8'h00, hi, lo});
        exp_a = {8'h00, hi, lo};
    endtask

    task automatic op_inc(logic [2:0] n, string req);
        inc_req = 1; inc_cnt = n; tick(); clr();
        exp_a = exp_a + 24'(n);
        check(req, fetch_addr, exp_a);
    endtask

    task automatic op_br(logic [15:0] off, string req);
        br_req = 1; br_off = off; tick(); clr();
        exp_a = exp_a + {{8{off[15]}}, off};
        check(req, fetch_addr, exp_a);
    endtask

    task automatic op_long(logic [7:0] b, logic [15:0] p);
        ld_long_req = 1; ld_bank = b; ld_pc = p; tick(); clr();
        exp_a = {b, p};
        check("R9 long load", fetch_addr, exp_a);
    endtask

    task automatic t_arith();
        op_inc(3'd3, "R5 advance");
        op_long(8'hFF, 16'hFFFE);
        op_inc(3'd5, "R5 R7 carry wraps bank");
        check("R7 bank 00", fetch_addr[23:16], 8'h00);
        op_br(16'hFFFC, "R6 R7 borrow wraps bank");
        check("R7 bank FF", fetch_addr[23:16], 8'hFF);
        op_br(16'h0002, "R6 forward carry");
        op_long(8'h05, 16'h8000);
        op_br(16'h7FFF, "R6 max positive");
        op_br(16'h0001, "R6 carry into bank");
        check("R6 bank 06", fetch_addr[23:16], 8'h06);
        op_br(16'hFFFF, "R6 borrow out of bank");
        check("R6 bank 05", fetch_addr[23:16], 8'h05);
        op_inc(3'd7, "R5 advance 7");
    endtask

    task automatic t_loads();
        ld_in_req = 1; ld_pc = 16'h0010; ld_bank = 8'hAA; tick(); clr();
        exp_a = {exp_a[23:16], 16'h0010};
        check("R8 in-bank load", fetch_addr, exp_a);
        tick(); tick();
        check("R11 idle hold", fetch_addr, exp_a);
    endtask

    task automatic t_prio();
        inc_req = 1; inc_cnt = 3'd1; br_req = 1; br_off = 16'h0100;
        ld_in_req = 1; ld_long_req = 1; ld_bank = 8'h12; ld_pc = 16'h3456; tick(); clr();
        exp_a = 24'h123456;
        check("R10 long first", fetch_addr, exp_a);
        inc_req = 1; inc_cnt = 3'd1; br_req = 1; br_off = 16'h0100;
        ld_in_req = 1; ld_bank = 8'h77; ld_pc = 16'h0ABC; tick(); clr();
        exp_a = 24'h120ABC;
        check("R10 in-bank over branch", fetch_addr, exp_a);
        inc_req = 1; inc_cnt = 3'd1; br_req = 1; br_off = 16'h0100; tick(); clr();
        exp_a = 24'h120BBC;
        check("R10 branch over advance", fetch_addr, exp_a);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        boot(8'h34, 8'h12);
        t_arith();
        t_loads();
        t_prio();
        boot(8'hCD, 8'hAB);
        op_inc(3'd1, "R5 after second start");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule